// File: doc/BRIEF.md
# Line-Code Balance and Run-Length Monitor

This block watches a serial stream of line-coded bits, one bit per clock while a valid strobe is high. Each 8-bit byte travels as a 10-bit symbol, so the stream carries 20% coding overhead. Only a small subset of the 10-bit patterns are usable codewords. The coding exists to keep the line DC balanced and to give the receiver enough edges to recover its clock. The monitor checks both of those properties directly on the stream. It does not decode symbols.

Balance is measured over a sliding window of the latest 20 valid bits. The window is a shift register. A signed ones-minus-zeros count is updated on every valid bit: the entering bit is added and the leaving bit is taken away. Once the window holds 20 bits, a count outside ±2 is a disparity violation. Transition density is checked by a run counter of identical bits. A sixth identical bit in a row is a run violation, wherever the symbol boundaries fall.

A three-state controller arms the balance check:
- `ST_IDLE`: no bit seen since reset.
- `ST_FILL`: the window is partly filled.
- `ST_ARMED`: the window is full.

Its transitions are:
- **first_bit**: `ST_IDLE` to `ST_FILL`, on the first valid bit.
- **window_full**: `ST_FILL` to `ST_ARMED`, on the 20th valid bit.
- **hold**: each state stays where it is on any other cycle.

The outputs are two sticky error flags, a one-cycle error pulse, the current window disparity and a pulse marking every tenth valid bit. Bits are taken least-significant first within each symbol.

Top module: `lcode_mon`

## Requirements
- R1: While reset is active and on the first cycle after it, `disp_o` is 0 and `run_err`, `disp_err`, `err_pulse` and `sym_edge` are all 0.
- R2: After the clock edge that accepts a valid bit, `disp_o` holds (number of ones) minus (number of zeros) over the last min(n, 20) valid bits, where n is the count of valid bits since reset. It is written as a 6-bit two's-complement value.
- R3: A valid bit that leaves the window disparity outside the range -2..+2 is a disparity violation. This applies only once at least 20 valid bits have arrived since reset, so the 20th bit is the first one checked. A violation sets `disp_err`. Exactly ±2 is not a violation.
- R4: A valid bit that makes the run of identical consecutive valid bits longer than 5 is a run violation, and it sets `run_err`. A run of exactly 5 is legal. A differing bit restarts the run at 1. Every further identical bit after the sixth is again a violation.
- R5: `err_pulse` is 1 in the cycle right after the edge that accepts a violating valid bit, and 0 in all other cycles.
- R6: `run_err` and `disp_err` stay at 1 until they are cleared through `clr_sticky`.
- R7: When `clr_sticky` is sampled high, each sticky flag is loaded with whether that same cycle carries a violation of its kind. A flag is therefore cleared, unless a valid bit in that cycle violates again, in which case it is set.
- R8: `sym_edge` is 1 for one cycle after every 10th valid bit since reset (the 10th, 20th, 30th, and so on), and 0 otherwise.
- R9: A cycle with `bit_vld` low changes neither the window, the disparity, the run count nor the symbol count, whatever the value on `bit_in`. In that cycle `err_pulse` and `sym_edge` are 0.
- R10: Alternating patterns raise no flag. These include a stream alternating 1,0 every bit and a stream of pairs 0,0,1,1 repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | Qualifies `bit_in` this cycle |
| bit_in | input | 1 | Serial line bit, LSB of each symbol first |
| clr_sticky | input | 1 | Synchronous clear of the sticky flags |
| disp_o | output | 6 | Signed ones-minus-zeros count of the window |
| run_err | output | 1 | Sticky run-length violation flag |
| disp_err | output | 1 | Sticky disparity violation flag |
| err_pulse | output | 1 | One-cycle pulse on any violation |
| sym_edge | output | 1 | Pulse after every tenth valid bit |

## Verification
The stimulus patterns each separate one failure mode from the others:
- Bit-wise and pair-wise alternating streams must stay silent.
- A "110" repeat breaks balance without ever breaking the run limit.
- A short stream with six leading zeros breaks the run limit before the window is armed, which shows that the balance check is suppressed during fill.
- A 20-bit stream ending at +2 and its 22-bit extension to +4 bracket the disparity limit.
- Five zeros followed by alternation brackets the run limit.

Directed sequences then cover:
- stalls with a toggling data line;
- a clear on an idle cycle;
- a clear landing on a violating bit;
- a long run at saturation.

A bench model computes window sums and run lengths from the stream and compares them bit by bit.

// File: rtl/lcm_pkg.sv
package lcm_pkg;

    // Arming controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_ARMED = 2'd2
    } mon_state_e;

    // Violations found on one accepted bit
    typedef struct packed {
        logic run;
        logic disp;
    } viol_t;

endpackage

// File: rtl/lcm_window.sv
module lcm_window #(
    parameter int WIN_BITS = 20,
    parameter int DISP_W   = $clog2(WIN_BITS + 1) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     shift_en,
    input  logic                     bit_in,
    input  logic                     win_full,
    output logic signed [DISP_W-1:0] disp_nxt,
    output logic signed [DISP_W-1:0] disp_q
);

    localparam logic signed [DISP_W-1:0] P_ONE  = DISP_W'(1);
    localparam logic signed [DISP_W-1:0] N_ONE  = -P_ONE;
    localparam logic signed [DISP_W-1:0] S_ZERO = '0;

    logic [WIN_BITS-1:0]       hist_q;
    logic signed [DISP_W-1:0]  enter_w;
    logic signed [DISP_W-1:0]  leave_w;

    // Oldest bit sits at the top once the window is full
    always_comb begin
        enter_w  = bit_in ? P_ONE : N_ONE;
        if (win_full) begin
            leave_w = hist_q[WIN_BITS-1] ? P_ONE : N_ONE;
        end else begin
            leave_w = S_ZERO;
        end
        disp_nxt = disp_q + enter_w - leave_w;
    end

    generate
        if (WIN_BITS == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hist_q <= '0;
                end else if (shift_en) begin
                    hist_q <= bit_in;
                end
            end
        end else begin : g_shift
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hist_q <= '0;
                end else if (shift_en) begin
                    hist_q <= {hist_q[WIN_BITS-2:0], bit_in};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            disp_q <= S_ZERO;
        end else if (shift_en) begin
            disp_q <= disp_nxt;
        end
    end

endmodule

// File: rtl/lcm_run.sv
module lcm_run #(
    parameter int RUN_LIM = 5,
    parameter int RUN_W   = $clog2(RUN_LIM + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic bit_in,
    input  logic first,
    output logic run_viol
);

    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LIM + 1);
    localparam logic [RUN_W-1:0] RUN_LEG = RUN_W'(RUN_LIM);
    localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);

    logic             prev_q;
    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_nxt;

    // Restart on a change, saturate one past the legal limit
    always_comb begin
        if (first || (bit_in != prev_q)) begin
            run_nxt = RUN_ONE;
        end else if (run_q == RUN_MAX) begin
            run_nxt = RUN_MAX;
        end else begin
            run_nxt = run_q + RUN_ONE;
        end
        run_viol = (run_nxt > RUN_LEG);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            run_q  <= '0;
        end else if (shift_en) begin
            prev_q <= bit_in;
            run_q  <= run_nxt;
        end
    end

endmodule

// File: rtl/lcm_symcnt.sv
module lcm_symcnt #(
    parameter int SYM_BITS = 10,
    parameter int SYM_W    = (SYM_BITS > 1) ? $clog2(SYM_BITS) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    output logic sym_edge
);

    generate
        if (SYM_BITS == 1) begin : g_every
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sym_edge <= 1'b0;
                end else begin
                    sym_edge <= shift_en;
                end
            end
        end else begin : g_count
            localparam logic [SYM_W-1:0] LAST = SYM_W'(SYM_BITS - 1);
            logic [SYM_W-1:0] pos_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pos_q    <= '0;
                    sym_edge <= 1'b0;
                end else begin
                    sym_edge <= shift_en && (pos_q == LAST);
                    if (shift_en) begin
                        pos_q <= (pos_q == LAST) ? '0 : pos_q + SYM_W'(1);
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/lcode_mon.sv
module lcode_mon
    import lcm_pkg::*;
#(
    parameter int WIN_BITS = 20,
    parameter int DISP_LIM = 2,
    parameter int RUN_LIM  = 5,
    parameter int SYM_BITS = 10,
    parameter int DISP_W   = $clog2(WIN_BITS + 1) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bit_vld,
    input  logic                     bit_in,
    input  logic                     clr_sticky,
    output logic signed [DISP_W-1:0] disp_o,
    output logic                     run_err,
    output logic                     disp_err,
    output logic                     err_pulse,
    output logic                     sym_edge
);

    localparam int FILL_W = $clog2(WIN_BITS + 1);
    localparam logic [FILL_W-1:0]        FILL_LAST = FILL_W'(WIN_BITS - 1);
    localparam logic signed [DISP_W-1:0] LIM_P     = DISP_W'(DISP_LIM);
    localparam logic signed [DISP_W-1:0] LIM_N     = -LIM_P;

    mon_state_e               state_q;
    mon_state_e               state_nxt;
    logic [FILL_W-1:0]        fill_q;
    logic signed [DISP_W-1:0] disp_nxt;
    logic                     run_viol;
    viol_t                    viol;

    lcm_window #(
        .WIN_BITS (WIN_BITS),
        .DISP_W   (DISP_W)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (bit_vld),
        .bit_in   (bit_in),
        .win_full (state_q == ST_ARMED),
        .disp_nxt (disp_nxt),
        .disp_q   (disp_o)
    );

    lcm_run #(
        .RUN_LIM (RUN_LIM)
    ) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (bit_vld),
        .bit_in   (bit_in),
        .first    (state_q == ST_IDLE),
        .run_viol (run_viol)
    );

    lcm_symcnt #(
        .SYM_BITS (SYM_BITS)
    ) u_sym (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (bit_vld),
        .sym_edge (sym_edge)
    );

    // Next-state: first_bit, window_full, hold
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (bit_vld) begin
                    state_nxt = (WIN_BITS == 1) ? ST_ARMED : ST_FILL;
                end
            end
            ST_FILL: begin
                if (bit_vld && (fill_q == FILL_LAST)) begin
                    state_nxt = ST_ARMED;
                end
            end
            ST_ARMED: begin
                state_nxt = ST_ARMED;
            end
            default: begin
                state_nxt = ST_IDLE;
            end
        endcase
    end

    // Violations of the bit accepted this cycle
    always_comb begin
        viol.run  = bit_vld && run_viol;
        viol.disp = bit_vld && (state_nxt == ST_ARMED) &&
                    ((disp_nxt > LIM_P) || (disp_nxt < LIM_N));
    end

    // State register with fill count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fill_q  <= '0;
        end else begin
            state_q <= state_nxt;
            if (bit_vld && (state_q != ST_ARMED)) begin
                fill_q <= fill_q + FILL_W'(1);
            end
        end
    end

    // Flag outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_err   <= 1'b0;
            disp_err  <= 1'b0;
            err_pulse <= 1'b0;
        end else begin
            err_pulse <= viol.run || viol.disp;
            run_err   <= (run_err && !clr_sticky) || viol.run;
            disp_err  <= (disp_err && !clr_sticky) || viol.disp;
        end
    end

endmodule

// File: rtl/lcm_chk.sv
module lcm_chk #(
    parameter int WIN_BITS = 20,
    parameter int DISP_W   = $clog2(WIN_BITS + 1) + 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bit_vld,
    input logic                     clr_sticky,
    input logic signed [DISP_W-1:0] disp_o,
    input logic                     run_err,
    input logic                     disp_err,
    input logic                     err_pulse,
    input logic                     sym_edge
);

    logic signed [DISP_W-1:0] disp_prev;
    logic signed [DISP_W:0]   disp_step;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            disp_prev <= '0;
        end else begin
            disp_prev <= disp_o;
        end
    end

    assign disp_step = (DISP_W + 1)'(disp_o) - (DISP_W + 1)'(disp_prev);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> ($stable(disp_o) && !err_pulse && !sym_edge));

    // R6
    run_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_err && !clr_sticky) |=> run_err);

    // R6
    disp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_err && !clr_sticky) |=> disp_err);

    // R5
    pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (run_err || disp_err));

    // R7
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sticky && !bit_vld) |=> (!run_err && !disp_err));

    // R2
    disp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |=> ((disp_step <= 2) && (disp_step >= -2)));

endmodule

bind lcode_mon lcm_chk #(
    .WIN_BITS (WIN_BITS),
    .DISP_W   (DISP_W)
) u_lcm_chk (.*);

// File: tb/tb_lcode_mon.sv
`timescale 1ns/1ps
module tb_lcode_mon;

    localparam int WIN = 20;
    localparam int LIM = 2;
    localparam int RUN = 5;
    localparam int SYM = 10;
    localparam int DW  = 6;

    typedef struct packed {
        logic [39:0]        pat;
        logic [5:0]         len;
        logic               exp_run;
        logic               exp_disp;
        logic signed [7:0]  exp_fin;
    } vec_t;

    // Bits are sent LSB first
    localparam vec_t VECS [7] = '{
        '{40'h5555555555, 6'd40, 1'b0, 1'b0, 8'sd0},  // R10 alternating
        '{40'hCCCCCCCCCC, 6'd40, 1'b0, 1'b0, 8'sd0},  // R10 pairs
        '{40'h0000000040, 6'd8,  1'b1, 1'b0, -8'sd6}, // R4 run, R3 unarmed
        '{40'hB6DB6DB6DB, 6'd40, 1'b0, 1'b1, 8'sd6},  // R3 110 repeat
        '{40'h00000D5555, 6'd20, 1'b0, 1'b0, 8'sd2},  // R3 exactly +2
        '{40'h00003D5555, 6'd22, 1'b0, 1'b1, 8'sd4},  // R3 reaches +4
        '{40'h00000002A0, 6'd10, 1'b0, 1'b0, -8'sd4}  // R4 run of five
    };

    logic clk = 1'b0;
    logic rst_n;
    logic bit_vld;
    logic bit_in;
    logic clr_sticky;
    logic signed [DW-1:0] disp_o;
    logic run_err;
    logic disp_err;
    logic err_pulse;
    logic sym_edge;

    always #2.5 clk = ~clk;

    lcode_mon dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_vld    (bit_vld),
        .bit_in     (bit_in),
        .clr_sticky (clr_sticky),
        .disp_o     (disp_o),
        .run_err    (run_err),
        .disp_err   (disp_err),
        .err_pulse  (err_pulse),
        .sym_edge   (sym_edge)
    );

    int   total = 0;
    int   bad   = 0;
    logic hist [WIN];
    int   nbits;
    int   run_m;
    int   symc;
    logic prev_m;
    logic m_run;
    logic m_disp;
    int   m_dispv;

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < WIN; i++) hist[i] = 1'b0;
        nbits = 0; run_m = 0; symc = 0; prev_m = 1'b0;
        m_run = 1'b0; m_disp = 1'b0; m_dispv = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bit_vld = 1'b0; bit_in = 1'b0; clr_sticky = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // Drive one cycle, then compare with the model after the edge
    task automatic step(input logic v, input logic b, input logic c);
        logic vr, vd, ep, es;
        int   n;
        bit_vld = v; bit_in = b; clr_sticky = c;
        @(negedge clk);
        vr = 1'b0; vd = 1'b0; es = 1'b0;
        if (v) begin
            for (int i = WIN - 1; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = b;
            nbits++;
            run_m = (nbits == 1 || b != prev_m) ? 1 : run_m + 1;
            prev_m = b;
            n = (nbits < WIN) ? nbits : WIN;
            m_dispv = 0;
            for (int i = 0; i < n; i++) m_dispv += hist[i] ? 1 : -1;
            vr = (run_m > RUN);
            vd = (nbits >= WIN) && (m_dispv > LIM || m_dispv < -LIM);
            symc = (symc + 1) % SYM;
            es = (symc == 0);
        end
        ep = vr | vd;
        m_run  = c ? vr : (m_run | vr);
        m_disp = c ? vd : (m_disp | vd);
        chk("R2", "disp_o", int'(disp_o), m_dispv);
        chk("R5", "err_pulse", int'(err_pulse), int'(ep));
        chk("R8", "sym_edge", int'(sym_edge), int'(es));
        chk("R4", "run_err", int'(run_err), int'(m_run));
        chk("R3", "disp_err", int'(disp_err), int'(m_disp));
    endtask

    initial begin
        #1000000;
        bad++; total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int held;
        // R1 reset state
        rst_n = 1'b0; bit_vld = 1'b0; bit_in = 1'b1; clr_sticky = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", "disp_o in reset", int'(disp_o), 0);
        chk("R1", "flags in reset", int'({run_err, disp_err, err_pulse, sym_edge}), 0);
        rst_n = 1'b1;
        bit_in = 1'b0;
        @(negedge clk);
        chk("R1", "flags after reset", int'({run_err, disp_err, err_pulse, sym_edge}), 0);

        // Vector table walk
        for (int k = 0; k < 7; k++) begin
            do_reset();
            for (int i = 0; i < int'(VECS[k].len); i++) step(1'b1, VECS[k].pat[i], 1'b0);
            chk("R4", $sformatf("vec%0d run_err", k), int'(run_err), int'(VECS[k].exp_run));
            chk("R3", $sformatf("vec%0d disp_err", k), int'(disp_err), int'(VECS[k].exp_disp));
            chk("R2", $sformatf("vec%0d disp_o", k), int'(disp_o), int'(VECS[k].exp_fin));
            if (k < 2) chk("R10", $sformatf("vec%0d no flag", k), int'(run_err | disp_err), 0);
        end

        // R9 stalls with a toggling data line
        do_reset();
        for (int i = 0; i < 15; i++) step(1'b1, i[0], 1'b0);
        held = int'(disp_o);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0);
        chk("R9", "disp held over stall", int'(disp_o), held);
        for (int i = 0; i < 10; i++) step(1'b1, ~i[0], 1'b0);
        chk("R9", "window untouched by stall", int'(run_err | disp_err), 0);

        // R6 / R7 sticky and clear, R4 saturation
        do_reset();
        for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0);
        chk("R6", "run_err held", int'(run_err), 1);
        step(1'b0, 1'b0, 1'b1);
        chk("R7", "idle clear", int'(run_err), 0);
        step(1'b1, 1'b0, 1'b1);
        chk("R7", "clear with violation sets", int'(run_err), 1);
        step(1'b1, 1'b1, 1'b1);
        chk("R7", "clear on clean bit", int'(run_err), 0);
        for (int i = 0; i < 12; i++) step(1'b1, 1'b1, 1'b0);
        chk("R4", "long run flagged", int'(err_pulse), 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule